// File: doc/BRIEF.md
# Toggle-Polled Parallel Flash Bank Programmer

This block erases and reprograms one sector of a byte-wide parallel flash device whose commands are only accepted after a two-write unlock handshake to fixed offsets. A single start request selects either a sector erase or a full-bank program. For a program the block fetches source bytes from a data port, indexed by the byte offset it is currently writing. The device has no status register. The block learns that an operation has finished by reading the bank base twice in a row. While the device is busy one bit toggles between the two reads. Once they agree, the operation is over.

After the erase or the last byte, the block issues the device reset command. It then reads back the whole bank and compares it against the all-ones erased pattern or against the source data. It finishes with a one-cycle done pulse carrying a result code. A busy phase that never ends is cut off after a parameterised number of toggle checks and reported as a timeout. Every command write is followed by a fixed settling gap, which is a parameter in clock cycles.

Top module: `toggle_flash_prog`

## Requirements
- R1: After reset, busy_o, done_o, fl_we_o and fl_re_o are all low until start_i is seen.
- R2: An erase (op_i = 0) issues exactly these writes, in order: 0xAA to 0x555, 0x55 to 0x2AA, 0x80 to 0x555, 0xAA to 0x555, 0x55 to 0x2AA, 0x30 to offset 0.
- R3: A program (op_i = 1) writes each bank offset in ascending order. Each offset gets 0xAA to 0x555, 0x55 to 0x2AA, 0xA0 to 0x555, and then src_data_i to that offset, with src_addr_o equal to that offset.
- R4: After every bus write there are exactly DELAY_CYC cycles with neither fl_we_o nor fl_re_o before the next bus access.
- R5: Completion is tested by two back-to-back reads of offset 0. The operation counts as finished only when both reads return the same byte. No further command is written while the device is busy, and busy phases of any length are waited out.
- R6: If MAX_CHECKS consecutive toggle checks all differ, the block stops the byte loop, writes the reset command, skips verification and reports result_o = 1 (timeout). The toggle reads before the reset write then number exactly 2*MAX_CHECKS.
- R7: When an operation ends, whether normally or by timeout, 0xF0 is written to offset 0. The DELAY_CYC gap of R4 follows it.
- R8: After an erase, every bank byte is read back. The result is 0 (ok) if all bytes read 0xFF and 2 (verify fail) otherwise.
- R9: After a program, every bank byte is read back and compared with src_data_i at the same offset. The result is 0 on a full match and 2 on any mismatch.
- R10: done_o is high for exactly one cycle per accepted start, with result_o valid in that cycle. busy_o stays high from acceptance until done. A start_i raised while busy has no effect on the bus traffic or the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, sampled while idle |
| op_i | input | 1 | 0 = sector erase, 1 = program bank |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 2 | 0 ok, 1 timeout, 2 verify fail |
| src_addr_o | output | ADDR_W | Offset of the source byte wanted |
| src_data_i | input | 8 | Source byte for src_addr_o, same cycle |
| fl_addr_o | output | ADDR_W | Flash byte offset |
| fl_wdata_o | output | 8 | Flash write data |
| fl_we_o | output | 1 | One-cycle write strobe |
| fl_re_o | output | 1 | One-cycle read strobe, data sampled at the same edge |
| fl_rdata_i | input | 8 | Flash read data |

## Verification
The pacing results are due at fixed points. Each write is followed by exactly DELAY_CYC idle cycles. The second toggle read comes on the cycle right after the first. The bench therefore measures the idle run after every write on each edge, and compares the shortest and longest against DELAY_CYC. The done pulse has a variable latency that depends on how long the device model stays busy. The bench waits edge by edge for done_o, samples result_o at the falling clock edge of that cycle, and checks one cycle later that the pulse has dropped. Write counts, toggle-read counts and memory contents are predicted from the per-byte busy lengths the bench itself chose.

// File: rtl/fp_pkg.sv
package fp_pkg;
  typedef enum logic {OP_ERASE = 1'b0, OP_PROG = 1'b1} op_e;
  typedef enum logic [1:0] {RES_OK = 2'd0, RES_TIMEOUT = 2'd1, RES_VERIFY = 2'd2} res_e;
  typedef enum logic [2:0] {
    S_IDLE, S_CMD, S_WAIT, S_POLL, S_RST, S_RSTW, S_VER, S_DONE
  } st_e;

  localparam logic [11:0] OFF_KEY_A = 12'h555;
  localparam logic [11:0] OFF_KEY_B = 12'h2AA;
  localparam logic [7:0]  D_KEY_A   = 8'hAA;
  localparam logic [7:0]  D_KEY_B   = 8'h55;
  localparam logic [7:0]  D_ERS_ARM = 8'h80;
  localparam logic [7:0]  D_ERS_GO  = 8'h30;
  localparam logic [7:0]  D_PRG_ARM = 8'hA0;
  localparam logic [7:0]  D_RESET   = 8'hF0;

  typedef struct packed {
    logic [11:0] off;
    logic [7:0]  data;
    logic        use_tgt;  // address/data come from the byte being programmed
    logic        last;
  } cmd_step_t;
endpackage

// File: rtl/fp_cmd_seq.sv
module fp_cmd_seq
  import fp_pkg::*;
(
  input  op_e        op_i,
  input  logic [2:0] step_i,
  output cmd_step_t  cmd_o
);
  always_comb begin
    cmd_o = '{off: 12'h000, data: 8'h00, use_tgt: 1'b0, last: 1'b0};
    if (step_i == 3'd0 || (op_i == OP_ERASE && step_i == 3'd3)) begin
      cmd_o.off  = OFF_KEY_A;
      cmd_o.data = D_KEY_A;
    end else if (step_i == 3'd1 || (op_i == OP_ERASE && step_i == 3'd4)) begin
      cmd_o.off  = OFF_KEY_B;
      cmd_o.data = D_KEY_B;
    end else if (step_i == 3'd2) begin
      cmd_o.off  = OFF_KEY_A;
      cmd_o.data = (op_i == OP_ERASE) ? D_ERS_ARM : D_PRG_ARM;
    end else if (op_i == OP_ERASE) begin
      cmd_o.data = D_ERS_GO;
      cmd_o.last = 1'b1;
    end else begin
      cmd_o.use_tgt = 1'b1;
      cmd_o.last    = 1'b1;
    end
  end
endmodule

// File: rtl/fp_pace.sv
module fp_pace #(
  parameter int DELAY_CYC = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic idle_o
);
  localparam int CW = (DELAY_CYC < 2) ? 1 : $clog2(DELAY_CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (load_i)           cnt_q <= CW'(DELAY_CYC - 1);
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign idle_o = (cnt_q == '0);

  a_r4_reload_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && DELAY_CYC > 1) |=> !idle_o);
endmodule

// File: rtl/fp_toggle.sv
module fp_toggle #(
  parameter int MAX_CHECKS = 1000000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [7:0] rdata_i,
  output logic       re_o,
  output logic       done_o,
  output logic       tmo_o
);
  localparam int CW = (MAX_CHECKS < 2) ? 1 : $clog2(MAX_CHECKS);

  typedef enum logic [1:0] {T_IDLE, T_RD1, T_RD2, T_DEC} tst_e;

  tst_e          st_q;
  logic [7:0]    first_q, diff_q;
  logic [CW-1:0] cnt_q;
  logic          last_chk;

  assign last_chk = (cnt_q == CW'(MAX_CHECKS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= T_IDLE;
      first_q <= '0;
      diff_q  <= '0;
      cnt_q   <= '0;
    end else begin
      case (st_q)
        T_IDLE: if (start_i) begin
          st_q  <= T_RD1;
          cnt_q <= '0;
        end
        T_RD1: begin
          first_q <= rdata_i;
          st_q    <= T_RD2;
        end
        T_RD2: begin
          diff_q <= first_q ^ rdata_i;
          st_q   <= T_DEC;
        end
        default: begin
          if (diff_q == '0 || last_chk) st_q <= T_IDLE;
          else begin
            cnt_q <= cnt_q + 1'b1;
            st_q  <= T_RD1;
          end
        end
      endcase
    end
  end

  assign re_o   = (st_q == T_RD1) || (st_q == T_RD2);
  assign done_o = (st_q == T_DEC) && (diff_q == '0 || last_chk);
  assign tmo_o  = (st_q == T_DEC) && (diff_q != '0) && last_chk;

  a_r5_pair_back_to_back: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == T_RD1) |=> re_o);
  a_r5_retry_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == T_DEC && diff_q != '0 && !last_chk) |=> re_o);
  a_r5_no_read_on_decide: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !re_o);
endmodule

// File: rtl/toggle_flash_prog.sv
module toggle_flash_prog
  import fp_pkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int BANK_BYTES = 8192,
  parameter int DELAY_CYC  = 50,
  parameter int MAX_CHECKS = 1000000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              op_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [1:0]        result_o,
  output logic [ADDR_W-1:0] src_addr_o,
  input  logic [7:0]        src_data_i,
  output logic [ADDR_W-1:0] fl_addr_o,
  output logic [7:0]        fl_wdata_o,
  output logic              fl_we_o,
  output logic              fl_re_o,
  input  logic [7:0]        fl_rdata_i
);
  localparam int IDX_W = $clog2(BANK_BYTES);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BANK_BYTES - 1);
  localparam int GW = (DELAY_CYC < 2) ? 1 : $clog2(DELAY_CYC + 1);

  st_e            st_q;
  op_e            op_q;
  logic [2:0]     step_q;
  logic [IDX_W-1:0] idx_q;
  logic           last_q, tmo_q;
  res_e           res_q;

  cmd_step_t      cmd;
  logic           pace_idle, pace_load;
  logic           tg_start, tg_re, tg_done, tg_tmo;
  logic [7:0]     expect_b;

  fp_cmd_seq u_seq (
    .op_i   (op_q),
    .step_i (step_q),
    .cmd_o  (cmd)
  );

  assign pace_load = (st_q == S_CMD) || (st_q == S_RST);

  fp_pace #(.DELAY_CYC(DELAY_CYC)) u_pace (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (pace_load),
    .idle_o (pace_idle)
  );

  assign tg_start = (st_q == S_WAIT) && pace_idle && last_q;

  fp_toggle #(.MAX_CHECKS(MAX_CHECKS)) u_tog (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (tg_start),
    .rdata_i (fl_rdata_i),
    .re_o    (tg_re),
    .done_o  (tg_done),
    .tmo_o   (tg_tmo)
  );

  assign expect_b = (op_q == OP_ERASE) ? 8'hFF : src_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      op_q   <= OP_ERASE;
      step_q <= '0;
      idx_q  <= '0;
      last_q <= 1'b0;
      tmo_q  <= 1'b0;
      res_q  <= RES_OK;
    end else begin
      case (st_q)
        S_IDLE: if (start_i) begin
          op_q   <= op_e'(op_i);
          step_q <= '0;
          idx_q  <= '0;
          tmo_q  <= 1'b0;
          st_q   <= S_CMD;
        end
        S_CMD: begin
          last_q <= cmd.last;
          if (!cmd.last) step_q <= step_q + 3'd1;
          st_q <= S_WAIT;
        end
        S_WAIT: if (pace_idle) st_q <= last_q ? S_POLL : S_CMD;
        S_POLL: if (tg_done) begin
          if (tg_tmo) begin
            tmo_q <= 1'b1;
            st_q  <= S_RST;
          end else if (op_q == OP_ERASE || idx_q == LAST_IDX) begin
            st_q <= S_RST;
          end else begin
            idx_q  <= idx_q + 1'b1;
            step_q <= '0;
            st_q   <= S_CMD;
          end
        end
        S_RST: st_q <= S_RSTW;
        S_RSTW: if (pace_idle) begin
          if (tmo_q) begin
            res_q <= RES_TIMEOUT;
            st_q  <= S_DONE;
          end else begin
            idx_q <= '0;
            st_q  <= S_VER;
          end
        end
        S_VER: begin
          if (fl_rdata_i != expect_b) begin
            res_q <= RES_VERIFY;
            st_q  <= S_DONE;
          end else if (idx_q == LAST_IDX) begin
            res_q <= RES_OK;
            st_q  <= S_DONE;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    fl_addr_o  = '0;
    fl_wdata_o = '0;
    if (st_q == S_CMD) begin
      fl_addr_o  = cmd.use_tgt ? ADDR_W'(idx_q) : ADDR_W'(cmd.off);
      fl_wdata_o = cmd.use_tgt ? src_data_i : cmd.data;
    end else if (st_q == S_RST) begin
      fl_wdata_o = D_RESET;
    end else if (st_q == S_VER) begin
      fl_addr_o = ADDR_W'(idx_q);
    end
  end

  assign fl_we_o    = (st_q == S_CMD) || (st_q == S_RST);
  assign fl_re_o    = tg_re || (st_q == S_VER);
  assign src_addr_o = ADDR_W'(idx_q);
  assign busy_o     = (st_q != S_IDLE);
  assign done_o     = (st_q == S_DONE);
  assign result_o   = res_q;

  // idle cycles since the last write, saturating; guards the pacing rule
  logic [GW-1:0] gap_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        gap_q <= GW'(DELAY_CYC);
    else if (fl_we_o)                   gap_q <= '0;
    else if (!fl_re_o && gap_q != GW'(DELAY_CYC)) gap_q <= gap_q + 1'b1;
  end

  a_r4_write_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fl_we_o || fl_re_o) |-> gap_q == GW'(DELAY_CYC));
  a_r1_bus_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fl_we_o && fl_re_o));
  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r10_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> op_q == $past(op_q));
  a_r6_no_cmd_after_tmo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmo_q && busy_o) |-> (st_q != S_CMD && st_q != S_VER));
  a_r10_result_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> result_o != 2'd3);
endmodule

// File: tb/sim_toggle_flash_prog.sv
module sim_toggle_flash_prog;
  localparam int AW = 13, NB = 64, DLY = 3, MAXC = 16, WD = 50000;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, start, op;
  logic busy, done;
  logic [1:0] result;
  logic [AW-1:0] src_addr, fl_addr;
  logic [7:0] src_data, fl_wdata, fl_rdata;
  logic fl_we, fl_re;

  toggle_flash_prog #(.ADDR_W(AW), .BANK_BYTES(NB), .DELAY_CYC(DLY), .MAX_CHECKS(MAXC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op),
    .busy_o(busy), .done_o(done), .result_o(result),
    .src_addr_o(src_addr), .src_data_i(src_data),
    .fl_addr_o(fl_addr), .fl_wdata_o(fl_wdata), .fl_we_o(fl_we), .fl_re_o(fl_re),
    .fl_rdata_i(fl_rdata)
  );

  int n_chk = 0, n_fail = 0;
  int unsigned seed_v;

  function automatic logic [7:0] src_fn(input int a, input int unsigned s);
    return 8'((a * 37) + s) ^ 8'(a >> 2);
  endfunction

  always_comb src_data = src_fn(int'(src_addr), seed_v);

  // device model
  logic [7:0] mem [NB];
  int  busy_left;
  logic tog;
  int  cst;
  int  erase_k;
  int  prog_k [NB];
  bit  stuck_en;
  int  stuck_a;
  // monitor
  int n_wr, n_rd_pre, bad, n_done, erase_seen, since_wr, min_gap, max_gap;
  bit rst_seen, pend;

  always_comb begin
    if (busy_left > 0) fl_rdata = tog ? 8'h40 : 8'h00;
    else if (int'(fl_addr) < NB)
      fl_rdata = mem[fl_addr[5:0]] & ((stuck_en && int'(fl_addr) == stuck_a) ? 8'hFE : 8'hFF);
    else fl_rdata = 8'hFF;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      busy_left <= 0; tog <= 1'b0; cst = 0;
    end else begin
      if (done) n_done++;
      if (fl_we || fl_re) begin
        if (pend) begin
          if (since_wr < min_gap) min_gap = since_wr;
          if (since_wr > max_gap) max_gap = since_wr;
        end
        pend = fl_we;
        since_wr = 0;
      end else since_wr++;
      if (fl_re) begin
        if (!rst_seen) n_rd_pre++;
        if (busy_left > 0) begin busy_left <= busy_left - 1; tog <= ~tog; end
      end
      if (fl_we) begin
        n_wr++;
        if (fl_wdata == 8'hF0) begin
          cst = 0; busy_left <= 0; rst_seen = 1;
        end else begin
          if (busy_left > 0) bad++;
          case (cst)
            0: if (fl_addr == 13'h555 && fl_wdata == 8'hAA) cst = 1; else bad++;
            1: if (fl_addr == 13'h2AA && fl_wdata == 8'h55) cst = 2; else begin bad++; cst = 0; end
            2: if (fl_addr == 13'h555 && fl_wdata == 8'h80) cst = 3;
               else if (fl_addr == 13'h555 && fl_wdata == 8'hA0) cst = 6;
               else begin bad++; cst = 0; end
            3: if (fl_addr == 13'h555 && fl_wdata == 8'hAA) cst = 4; else begin bad++; cst = 0; end
            4: if (fl_addr == 13'h2AA && fl_wdata == 8'h55) cst = 5; else begin bad++; cst = 0; end
            5: begin
              if (fl_addr == 13'h000 && fl_wdata == 8'h30) begin
                for (int i = 0; i < NB; i++) mem[i] <= 8'hFF;
                busy_left <= 2 * erase_k; erase_seen++;
              end else bad++;
              cst = 0;
            end
            default: begin
              if (int'(fl_addr) < NB) begin
                mem[fl_addr[5:0]] <= mem[fl_addr[5:0]] & fl_wdata;
                busy_left <= 2 * prog_k[fl_addr[5:0]];
              end else bad++;
              cst = 0;
            end
          endcase
        end
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clr_mon();
    n_wr = 0; n_rd_pre = 0; bad = 0; n_done = 0; erase_seen = 0;
    since_wr = 0; min_gap = 1 << 30; max_gap = 0; rst_seen = 0; pend = 0;
  endtask

  // runs one operation; optional stray start with the other op after 'poke' cycles
  task automatic run_op(input logic o, input int poke, output int res);
    int cyc;
    @(negedge clk);
    clr_mon();
    op = o; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < WD) begin
      @(negedge clk);
      cyc++;
      if (poke > 0 && cyc == poke) begin op = ~o; start = 1'b1; end
      else start = 1'b0;
    end
    if (cyc >= WD) begin
      n_chk++; n_fail++;
      $display("FAIL R10: watchdog, actual no done expected done");
      res = -1;
    end else res = int'(result);
    @(negedge clk);
    chk("R10 done width", n_done, 1);
    chk("R10 busy after done", int'(busy), 0);
  endtask

  initial begin
    int res, exp_rd;
    seed_v = $urandom(32'd2024);
    seed_v = $urandom;
    rst_n = 1'b0; start = 1'b0; op = 1'b0;
    stuck_en = 0; stuck_a = 0; erase_k = 3;
    for (int i = 0; i < NB; i++) begin mem[i] = 8'h00; prog_k[i] = 0; end
    clr_mon();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 strobes", int'(fl_we) + int'(fl_re), 0);

    // normal erase: R2 R4 R5 R7 R8
    run_op(1'b0, 0, res);
    chk("R8 erase ok", res, 0);
    chk("R2 bad writes", bad, 0);
    chk("R2 erase issued", erase_seen, 1);
    chk("R7 write count", n_wr, 7);
    chk("R7 reset seen", int'(rst_seen), 1);
    chk("R5 poll reads", n_rd_pre, 2 * (erase_k + 1));
    chk("R4 min gap", min_gap, DLY);
    chk("R4 max gap", max_gap, DLY);

    // random program: R3 R5 R9
    exp_rd = 0;
    for (int i = 0; i < NB; i++) begin prog_k[i] = int'($urandom % 4); exp_rd += 2 * (prog_k[i] + 1); end
    run_op(1'b1, 0, res);
    chk("R9 program ok", res, 0);
    chk("R3 bad writes", bad, 0);
    chk("R3 write count", n_wr, 4 * NB + 1);
    chk("R5 poll reads", n_rd_pre, exp_rd);
    chk("R4 max gap", max_gap, DLY);
    begin
      int mism = 0;
      for (int i = 0; i < NB; i++) if (mem[i] != src_fn(i, seed_v)) mism++;
      chk("R3 memory image", mism, 0);
    end

    // erase timeout: R6 R7
    erase_k = 1000;
    run_op(1'b0, 0, res);
    chk("R6 erase timeout", res, 1);
    chk("R6 toggle reads", n_rd_pre, 2 * MAXC);
    chk("R7 write count", n_wr, 7);
    erase_k = 2;
    run_op(1'b0, 0, res);
    chk("R8 erase ok again", res, 0);

    // program timeout at byte 5: R6
    for (int i = 0; i < NB; i++) prog_k[i] = 1;
    prog_k[5] = 1000;
    run_op(1'b1, 0, res);
    chk("R6 program timeout", res, 1);
    chk("R6 writes stop", n_wr, 4 * 6 + 1);
    chk("R6 toggle reads", n_rd_pre, 5 * 4 + 2 * MAXC);
    chk("R6 bad writes", bad, 0);
    prog_k[5] = 0;

    // stuck cell: erase verify fail R8
    stuck_en = 1; stuck_a = 9;
    run_op(1'b0, 0, res);
    chk("R8 erase verify fail", res, 2);

    // program verify with stuck bit: fail when source bit0 set, ok when clear (R9)
    seed_v = 32'd1;
    for (int i = 0; i < NB; i++) if (src_fn(i, seed_v)[0] && stuck_a == 9) begin stuck_a = i; break; end
    run_op(1'b0, 0, res); // reprogram flash to erased
    run_op(1'b1, 0, res);
    chk("R9 verify fail", res, src_fn(stuck_a, seed_v)[0] ? 2 : 0);
    for (int i = 0; i < NB; i++) if (!src_fn(i, seed_v)[0]) begin stuck_a = i; break; end
    run_op(1'b0, 0, res);
    chk("R8 erase with zero-stuck fail", res, 2);
    run_op(1'b1, 0, res);
    chk("R9 stuck bit matches", res, 0);
    stuck_en = 0;

    // stray start while busy: R10
    run_op(1'b0, 0, res);
    run_op(1'b1, 120, res);
    chk("R10 stray start result", res, 0);
    chk("R10 stray start writes", n_wr, 4 * NB + 1);
    chk("R10 stray start no erase", erase_seen, 0);
    chk("R10 stray start bad", bad, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R10: global watchdog, actual running expected finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule